// File: doc/BRIEF.md
# Elastic-Store Jitter Attenuator

This block is a single-bit elastic store that smooths a bursty or gapped bit stream into a read stream whose strobes are evenly spaced. Writes arrive as a data bit with a write strobe that may skip cycles. Reads are paced by a phase accumulator that is clocked by the system clock. On each cycle the accumulator adds a nominal increment plus a correction proportional to the error between the fill level and half depth. The gain of that correction is a right shift. The shift is large, giving a narrow loop, during normal operation. It is small, giving a wide loop, while the fill level lies within two entries of empty or full, so that the read rate follows the input closely and no bit is lost.

The store can be inserted into a receive stream or a transmit stream, or taken out of both. A stream that is not routed through the store passes combinationally from its input to its output. Line mode, depth select and a narrow-bandwidth select together fix the depth and the narrow loop gain. Any change to that resolved setting recentres the pointers at half depth. A genuine overflow also recentres them and sets a sticky error flag.

Top module: `ja_elastic_store`

## Requirements
- R1: After reset the read pointer sits half the depth behind the write pointer. With `deep_sel_i`=0 the depth is 32, and the first written bit is the 17th bit read, the 16 bits before it being 0. With `deep_sel_i`=1 the depth is 64, and the first written bit is the 33rd bit read.
- R2: In E1 mode (`line_e1_i`=1) with `narrow_bw_i`=1, the depth is 64 whatever `deep_sel_i` is, and the narrowest loop gain is used.
- R3: In T1 mode (`line_e1_i`=0), `narrow_bw_i` has no effect. The depth follows `deep_sel_i` alone.
- R4: When writes arrive at the nominal average rate of one per 4 clocks with random spacing of 3 to 5 clocks, every written bit comes out in order, after the half-depth leading bits, and `slip_err_o` stays 0.
- R5: A gap of 20 missing bit periods at depth 32, or 50 at depth 64, followed by a catch-up at one write per 3 clocks, causes no loss and no error.
- R6: While the fill level is at most 2 or at least depth-2, `fast_track_o` is 1 and the wide loop is active. Near empty, reads stop. With no writes the store therefore drains to exactly 2 entries, so the total number of reads equals half depth plus writes minus 2. A sustained write rate of one per 2 clocks drives the fill level into the upper window.
- R7: The read strobe is never high on two consecutive cycles. With steady writes every 4 clocks and the narrow loop active, consecutive read strobes are 3 to 5 clocks apart.
- R8: A write into a full store with no read in the same cycle sets `slip_err_o`, which stays 1 until reset, and recentres the fill level at half depth.
- R9: A change of the resolved depth, loop gain or path recentres the store at half the new depth. At depth 64 with no writes, 30 further reads follow.
- R10: `path_sel_i` encoding: 2'b01 routes the receive stream through the store, 2'b10 routes the transmit stream through it, and 2'b00 and 2'b11 bypass both. A stream that is not routed through the store passes combinationally from input to output.
- R11: During reset the store outputs a read strobe of 0, `fast_track_o`=0 and `slip_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_e1_i | input | 1 | 1 = E1 mode, 0 = T1 mode |
| deep_sel_i | input | 1 | 1 = depth 64, 0 = depth 32 |
| narrow_bw_i | input | 1 | Narrowest loop select (E1 only) |
| path_sel_i | input | 2 | Placement of the store |
| rx_bit_i | input | 1 | Receive stream data in |
| rx_stb_i | input | 1 | Receive stream strobe in |
| tx_bit_i | input | 1 | Transmit stream data in |
| tx_stb_i | input | 1 | Transmit stream strobe in |
| rx_bit_o | output | 1 | Receive stream data out |
| rx_stb_o | output | 1 | Receive stream strobe out |
| tx_bit_o | output | 1 | Transmit stream data out |
| tx_stb_o | output | 1 | Transmit stream strobe out |
| fast_track_o | output | 1 | Wide loop active |
| slip_err_o | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench counts reads to pin down the half-depth offset for each combination of mode, depth and narrow select. A design that resolved the depth wrongly would deliver the first bit at the 17th read where the 33rd is due, or the reverse. Draining runs check that reads stop with exactly two entries left; a wide loop that engaged late, or not at all, would underflow and raise the error. Gapped and randomly spaced writes are compared bit by bit against a queue, so any slip or reordering shows up. Forced overflow, a configuration change during operation, and each path encoding check the recentre, the sticky flag and the combinational pass-through.

// File: rtl/ja_pkg.sv
package ja_pkg;

    typedef enum logic [1:0] {
        PATH_OFF     = 2'b00,
        PATH_RX      = 2'b01,
        PATH_TX      = 2'b10,
        PATH_OFF_ALT = 2'b11
    } path_e;

    typedef struct packed {
        logic       deep;
        logic [3:0] shift;
        path_e      path;
    } cfg_res_t;

    function automatic logic path_active(path_e p);
        return (p == PATH_RX) || (p == PATH_TX);
    endfunction

    function automatic logic deep_resolve(logic e1, logic narrow, logic deep_sel);
        return (e1 && narrow) || deep_sel;
    endfunction

endpackage

// File: rtl/ja_cfg.sv
module ja_cfg
    import ja_pkg::*;
#(
    parameter int unsigned SH_T1        = 6,
    parameter int unsigned SH_E1        = 5,
    parameter int unsigned SH_E1_NARROW = 7
) (
    input  logic       clk,
    input  logic       line_e1,
    input  logic       narrow_bw,
    input  logic       deep_sel,
    input  path_e      path,
    output logic       deep_eff,
    output logic [3:0] shift_norm,
    output logic       fifo_on,
    output logic       recentre
);

    cfg_res_t res_d, res_q;

    always_comb begin
        res_d.deep = deep_resolve(line_e1, narrow_bw, deep_sel);
        if (!line_e1)
            res_d.shift = 4'(SH_T1);
        else if (narrow_bw)
            res_d.shift = 4'(SH_E1_NARROW);
        else
            res_d.shift = 4'(SH_E1);
        res_d.path = path;
    end

    // Resolved setting of the previous cycle; a difference forces a recentre.
    always_ff @(posedge clk) begin
        res_q <= res_d;
    end

    assign deep_eff   = res_d.deep;
    assign shift_norm = res_d.shift;
    assign fifo_on    = path_active(res_d.path);
    assign recentre   = (res_d != res_q) || !fifo_on;

endmodule

// File: rtl/ja_store.sv
module ja_store #(
    parameter int unsigned DEPTH_LO = 32,
    parameter int unsigned DEPTH_HI = 64,
    parameter int unsigned NEAR     = 2,
    parameter int unsigned FW       = $clog2(DEPTH_HI + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          deep,
    input  logic          recentre,
    input  logic          wr_en,
    input  logic          wr_bit,
    input  logic          rd_req,
    output logic          rd_bit,
    output logic          rd_stb,
    output logic [FW-1:0] fill,
    output logic [FW-1:0] half,
    output logic          near_q,
    output logic          err_q
);

    localparam int unsigned AW = $clog2(DEPTH_HI);

    logic          mem [DEPTH_HI];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [FW-1:0] depth, fill_n;
    logic          do_rd, udf, ovf, fault, near_n;

    function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p, logic [FW-1:0] d);
        return (p == AW'(d - FW'(1))) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        depth  = deep ? FW'(DEPTH_HI) : FW'(DEPTH_LO);
        half   = depth >> 1;
        do_rd  = rd_req && (fill != '0);
        udf    = rd_req && (fill == '0);
        ovf    = wr_en && (fill == depth) && !do_rd;
        fault  = udf || ovf;
        if (recentre || fault)
            fill_n = half;
        else
            fill_n = fill + FW'(wr_en) - FW'(do_rd);
        near_n = (fill_n <= FW'(NEAR)) || (fill_n >= depth - FW'(NEAR));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= AW'(depth - half);
            fill   <= half;
            rd_stb <= 1'b0;
            rd_bit <= 1'b0;
            near_q <= 1'b0;
            err_q  <= 1'b0;
            for (int i = 0; i < int'(DEPTH_HI); i++) mem[i] <= 1'b0;
        end else if (recentre || fault) begin
            wr_ptr <= '0;
            rd_ptr <= AW'(depth - half);
            fill   <= fill_n;
            rd_stb <= 1'b0;
            near_q <= near_n;
            err_q  <= err_q || fault;
        end else begin
            if (wr_en) begin
                mem[wr_ptr] <= wr_bit;
                wr_ptr      <= ptr_next(wr_ptr, depth);
            end
            if (do_rd) begin
                rd_bit <= mem[rd_ptr];
                rd_ptr <= ptr_next(rd_ptr, depth);
            end
            rd_stb <= do_rd;
            fill   <= fill_n;
            near_q <= near_n;
        end
    end

    p_fill_bound_r1: assert property (@(posedge clk) disable iff (rst)
        fill <= depth);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    p_ovf_recentre_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (fill == depth) && !rd_req && !recentre) |=> (err_q && fill == $past(half)));

    p_recentre_half_r9: assert property (@(posedge clk) disable iff (rst)
        recentre |=> (fill == $past(half)));

endmodule

// File: rtl/ja_rate.sv
module ja_rate #(
    parameter int unsigned ACC_W   = 16,
    parameter int unsigned NOM_LOG = 14,
    parameter int unsigned SH_WIDE = 2,
    parameter int unsigned FW      = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          wide,
    input  logic [3:0]    shift_norm,
    input  logic [FW-1:0] fill,
    input  logic [FW-1:0] half,
    output logic          rd_req
);

    localparam int unsigned IW_A = FW + NOM_LOG + 2;
    localparam int unsigned IW   = (IW_A > ACC_W + 2) ? IW_A : ACC_W + 2;
    localparam int unsigned NOM  = 1 << NOM_LOG;

    logic [ACC_W-1:0]    acc;
    logic [ACC_W:0]      inc, sum;
    logic signed [IW-1:0] err_s, off_s, raw_s;
    logic [3:0]          sh;

    always_comb begin
        sh    = wide ? 4'(SH_WIDE) : shift_norm;
        err_s = $signed(IW'(fill)) - $signed(IW'(half));
        off_s = (err_s <<< NOM_LOG) >>> sh;
        raw_s = off_s + $signed(IW'(NOM));
        if (raw_s < 0)
            inc = '0;
        else if (raw_s > $signed(IW'(2 * NOM)))
            inc = (ACC_W + 1)'(2 * NOM);
        else
            inc = (ACC_W + 1)'(raw_s);
        sum    = {1'b0, acc} + inc;
        rd_req = sum[ACC_W] && !hold;
    end

    always_ff @(posedge clk) begin
        if (rst || hold)
            acc <= '0;
        else
            acc <= sum[ACC_W-1:0];
    end

endmodule

// File: rtl/ja_elastic_store.sv
module ja_elastic_store
    import ja_pkg::*;
#(
    parameter int unsigned DEPTH_LO     = 32,
    parameter int unsigned DEPTH_HI     = 64,
    parameter int unsigned NEAR         = 2,
    parameter int unsigned ACC_W        = 16,
    parameter int unsigned NOM_LOG      = 14,
    parameter int unsigned SH_WIDE      = 2,
    parameter int unsigned SH_E1        = 5,
    parameter int unsigned SH_T1        = 6,
    parameter int unsigned SH_E1_NARROW = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_e1_i,
    input  logic       deep_sel_i,
    input  logic       narrow_bw_i,
    input  logic [1:0] path_sel_i,
    input  logic       rx_bit_i,
    input  logic       rx_stb_i,
    input  logic       tx_bit_i,
    input  logic       tx_stb_i,
    output logic       rx_bit_o,
    output logic       rx_stb_o,
    output logic       tx_bit_o,
    output logic       tx_stb_o,
    output logic       fast_track_o,
    output logic       slip_err_o
);

    localparam int unsigned FILL_W = $clog2(DEPTH_HI + 1);

    path_e             path;
    logic              deep_eff, fifo_on, recentre;
    logic [3:0]        shift_norm;
    logic              st_wr, st_wbit, st_bit, st_stb, rd_req;
    logic [FILL_W-1:0] st_fill, st_half;

    assign path = path_e'(path_sel_i);

    ja_cfg #(
        .SH_T1(SH_T1), .SH_E1(SH_E1), .SH_E1_NARROW(SH_E1_NARROW)
    ) u_cfg (
        .clk(clk), .line_e1(line_e1_i), .narrow_bw(narrow_bw_i),
        .deep_sel(deep_sel_i), .path(path), .deep_eff(deep_eff),
        .shift_norm(shift_norm), .fifo_on(fifo_on), .recentre(recentre)
    );

    always_comb begin
        st_wr   = 1'b0;
        st_wbit = 1'b0;
        if (path == PATH_RX) begin
            st_wr   = rx_stb_i;
            st_wbit = rx_bit_i;
        end else if (path == PATH_TX) begin
            st_wr   = tx_stb_i;
            st_wbit = tx_bit_i;
        end
    end

    ja_store #(
        .DEPTH_LO(DEPTH_LO), .DEPTH_HI(DEPTH_HI), .NEAR(NEAR), .FW(FILL_W)
    ) u_store (
        .clk(clk), .rst(rst), .deep(deep_eff), .recentre(recentre),
        .wr_en(st_wr && fifo_on), .wr_bit(st_wbit), .rd_req(rd_req),
        .rd_bit(st_bit), .rd_stb(st_stb), .fill(st_fill), .half(st_half),
        .near_q(fast_track_o), .err_q(slip_err_o)
    );

    ja_rate #(
        .ACC_W(ACC_W), .NOM_LOG(NOM_LOG), .SH_WIDE(SH_WIDE), .FW(FILL_W)
    ) u_rate (
        .clk(clk), .rst(rst), .hold(recentre), .wide(fast_track_o),
        .shift_norm(shift_norm), .fill(st_fill), .half(st_half), .rd_req(rd_req)
    );

    always_comb begin
        rx_bit_o = rx_bit_i;
        rx_stb_o = rx_stb_i;
        tx_bit_o = tx_bit_i;
        tx_stb_o = tx_stb_i;
        if (path == PATH_RX) begin
            rx_bit_o = st_bit;
            rx_stb_o = st_stb;
        end else if (path == PATH_TX) begin
            tx_bit_o = st_bit;
            tx_stb_o = st_stb;
        end
    end

    p_no_back_to_back_r7: assert property (@(posedge clk) disable iff (rst)
        st_stb |=> !st_stb);

    p_pause_near_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (fast_track_o && (st_fill <= FILL_W'(NEAR)) && !recentre) |=> !st_stb);

endmodule

// File: tb/ja_elastic_store_tb_top.sv
module ja_elastic_store_tb_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       line_e1 = 0, deep_sel = 0, narrow_bw = 0;
    logic [1:0] path_sel = 2'b01;
    logic       rx_bit_i = 0, rx_stb_i = 0, tx_bit_i = 0, tx_stb_i = 0;
    logic       rx_bit_o, rx_stb_o, tx_bit_o, tx_stb_o, fast_track_o, slip_err_o;

    ja_elastic_store dut_i (
        .clk(clk), .rst(rst), .line_e1_i(line_e1), .deep_sel_i(deep_sel),
        .narrow_bw_i(narrow_bw), .path_sel_i(path_sel),
        .rx_bit_i(rx_bit_i), .rx_stb_i(rx_stb_i), .tx_bit_i(tx_bit_i), .tx_stb_i(tx_stb_i),
        .rx_bit_o(rx_bit_o), .rx_stb_o(rx_stb_o), .tx_bit_o(tx_bit_o), .tx_stb_o(tx_stb_o),
        .fast_track_o(fast_track_o), .slip_err_o(slip_err_o)
    );

    int checks = 0, errors = 0;
    bit exp_q[$];
    bit use_tx = 0, data_chk = 0, spc_en = 0, first_wr = 0;
    int rd_cnt = 0, first_one = -1, cyc = 0, last_rd = -1;
    int gap_min = 1000, gap_max = 0, wr_cnt = 0, fast_seen = 0;

    task automatic fail(input string req, input int act, input int exp);
        errors++;
        $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) fail(req, act, exp);
    endtask

    function automatic int half_of(bit e1, bit deep, bit narrow);
        return ((e1 && narrow) || deep) ? 32 : 16;
    endfunction

    // Read monitor: compares every read bit against the expected queue.
    always @(negedge clk) begin
        logic s, b;
        cyc++;
        s = use_tx ? tx_stb_o : rx_stb_o;
        b = use_tx ? tx_bit_o : rx_bit_o;
        if (fast_track_o) fast_seen++;
        if (!rst && s) begin
            rd_cnt++;
            if (b && first_one < 0) first_one = rd_cnt;
            if (data_chk) begin
                checks++;
                if (exp_q.size() == 0) fail("R4 read with empty expectation", 1, 0);
                else begin
                    bit e;
                    e = exp_q.pop_front();
                    if (b !== e) fail("R4 data order", int'(b), int'(e));
                end
            end
            if (spc_en && !fast_track_o && rd_cnt > 20) begin
                if (last_rd >= 0) begin
                    if (cyc - last_rd < gap_min) gap_min = cyc - last_rd;
                    if (cyc - last_rd > gap_max) gap_max = cyc - last_rd;
                end
                last_rd = cyc;
            end
        end
    end

    task automatic tick(input bit we);
        bit b;
        @(negedge clk);
        b = first_wr ? 1'b1 : 1'($urandom_range(0, 1));
        if (we) begin
            first_wr = 0;
            wr_cnt++;
            exp_q.push_back(b);
        end
        if (use_tx) begin tx_stb_i = we; tx_bit_i = b; end
        else        begin rx_stb_i = we; rx_bit_i = b; end
    endtask

    task automatic start(input bit e1, input bit deep, input bit narrow, input bit tx, input bit chk_rst);
        @(negedge clk);
        rst = 1; line_e1 = e1; deep_sel = deep; narrow_bw = narrow;
        use_tx = tx; path_sel = tx ? 2'b10 : 2'b01;
        rx_stb_i = 0; tx_stb_i = 0; data_chk = 0; spc_en = 0;
        repeat (3) @(negedge clk);
        if (chk_rst) begin
            check("R11 reset strobe", int'(tx ? tx_stb_o : rx_stb_o), 0);
            check("R11 reset fast_track", int'(fast_track_o), 0);
            check("R11 reset slip_err", int'(slip_err_o), 0);
        end
        rst = 0;
        exp_q.delete();
        for (int i = 0; i < half_of(e1, deep, narrow); i++) exp_q.push_back(1'b0);
        rd_cnt = 0; first_one = -1; wr_cnt = 0; first_wr = 1;
        last_rd = -1; gap_min = 1000; gap_max = 0; fast_seen = 0;
        data_chk = 1;
    endtask

    task automatic latency_run(input bit e1, input bit deep, input bit narrow, input bit tx,
                               input string req, input int exp_idx);
        start(e1, deep, narrow, tx, 0);
        for (int i = 0; i < 120; i++) begin tick(1); repeat (3) tick(0); end
        repeat (200) tick(0);
        check(req, first_one, exp_idx);
        check({req, " no error"}, int'(slip_err_o), 0);
    endtask

    task automatic bypass_chk(input logic [1:0] p, input bit rx_pass, input bit tx_pass);
        @(negedge clk);
        path_sel = p; rx_bit_i = 1; rx_stb_i = 1; tx_bit_i = 0; tx_stb_i = 1;
        #1;
        if (rx_pass) begin
            check("R10 rx bit pass", int'(rx_bit_o), 1);
            check("R10 rx stb pass", int'(rx_stb_o), 1);
        end
        if (tx_pass) begin
            check("R10 tx bit pass", int'(tx_bit_o), 0);
            check("R10 tx stb pass", int'(tx_stb_o), 1);
        end
        @(negedge clk);
        rx_bit_i = 0; tx_bit_i = 1;
        #1;
        if (rx_pass) check("R10 rx bit follows", int'(rx_bit_o), 0);
        if (tx_pass) check("R10 tx bit follows", int'(tx_bit_o), 1);
        rx_stb_i = 0; tx_stb_i = 0;
    endtask

    initial begin
        #(4 * 190000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt0;
        void'($urandom(32'd20240));

        // R11 reset state, then R1 depth-32 latency with R7 spacing
        start(0, 0, 0, 0, 1);
        spc_en = 1;
        for (int i = 0; i < 120; i++) begin tick(1); repeat (3) tick(0); end
        spc_en = 0;
        repeat (200) tick(0);
        check("R1 first bit index depth 32", first_one, 17);
        check("R7 min read spacing ok", int'(gap_min >= 3), 1);
        check("R7 max read spacing ok", int'(gap_max <= 5 && gap_max > 0), 1);

        latency_run(0, 1, 0, 0, "R1 first bit index depth 64", 33);
        latency_run(1, 0, 1, 0, "R2 E1 narrow forces depth 64", 33);
        latency_run(0, 0, 1, 0, "R3 T1 ignores narrow select", 17);
        latency_run(0, 0, 0, 1, "R10 transmit placement latency", 17);

        // R4 random spacing, receive path, E1 depth 32
        start(1, 0, 0, 0, 0);
        for (int i = 0; i < 600; i++) begin tick(1); repeat ($urandom_range(2, 4)) tick(0); end
        repeat (400) tick(0);
        check("R4 random no error", int'(slip_err_o), 0);
        check("R4 random read total", rd_cnt, 16 + wr_cnt - 2);

        // R4 random spacing, transmit path, T1 depth 64
        start(0, 1, 0, 1, 0);
        for (int i = 0; i < 600; i++) begin tick(1); repeat ($urandom_range(2, 4)) tick(0); end
        repeat (600) tick(0);
        check("R4 random depth 64 no error", int'(slip_err_o), 0);
        check("R4 random depth 64 read total", rd_cnt, 32 + wr_cnt - 2);

        // R5 gap of 20 bit periods at depth 32
        start(0, 0, 0, 0, 0);
        for (int i = 0; i < 100; i++) begin tick(1); repeat (3) tick(0); end
        repeat (80) tick(0);
        for (int i = 0; i < 60; i++) begin tick(1); repeat (2) tick(0); end
        for (int i = 0; i < 100; i++) begin tick(1); repeat (3) tick(0); end
        repeat (400) tick(0);
        check("R5 gap 20 no error", int'(slip_err_o), 0);
        check("R5 gap 20 read total", rd_cnt, 16 + wr_cnt - 2);

        // R5 gap of 50 bit periods at depth 64
        start(0, 1, 0, 0, 0);
        for (int i = 0; i < 100; i++) begin tick(1); repeat (3) tick(0); end
        repeat (200) tick(0);
        for (int i = 0; i < 150; i++) begin tick(1); repeat (2) tick(0); end
        for (int i = 0; i < 100; i++) begin tick(1); repeat (3) tick(0); end
        repeat (600) tick(0);
        check("R5 gap 50 no error", int'(slip_err_o), 0);
        check("R5 gap 50 read total", rd_cnt, 32 + wr_cnt - 2);

        // R6 near full: writes every 2 clocks
        start(0, 0, 0, 0, 0);
        fast_seen = 0;
        for (int i = 0; i < 200; i++) begin tick(1); tick(0); end
        check("R6 wide loop entered near full", int'(fast_seen > 0), 1);
        check("R6 near full no overflow", int'(slip_err_o), 0);
        repeat (400) tick(0);
        check("R6 drain after burst", rd_cnt, 16 + wr_cnt - 2);

        // R6 drain to two entries, then R9 recentre on depth change
        start(0, 0, 0, 0, 0);
        repeat (400) tick(0);
        check("R6 idle drain reads", rd_cnt, 14);
        check("R6 fast_track near empty", int'(fast_track_o), 1);
        data_chk = 0;
        @(negedge clk);
        deep_sel = 1;
        cnt0 = rd_cnt;
        repeat (600) tick(0);
        check("R9 reads after recentre to 64", rd_cnt - cnt0, 30);
        check("R9 fast_track after drain", int'(fast_track_o), 1);

        // R8 forced overflow
        start(0, 0, 0, 0, 0);
        data_chk = 0;
        repeat (100) tick(1);
        check("R8 overflow sets error", int'(slip_err_o), 1);
        repeat (200) tick(0);
        check("R8 error sticky", int'(slip_err_o), 1);

        // R10 path encodings
        data_chk = 0;
        bypass_chk(2'b00, 1, 1);
        bypass_chk(2'b11, 1, 1);
        bypass_chk(2'b01, 0, 1);
        bypass_chk(2'b10, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule